// File: doc/BRIEF.md
# Nonvolatile Page Commit Controller

This block keeps a bank of byte-wide shadow registers coherent with a nonvolatile backing array, which is modelled here as plain registers with a write enable. Bus writes arrive as a stream of address/data beats and land in the shadow bank at once. Two of the shadow bytes drive the codes of two resistor outputs, and a configuration byte holds one high-impedance bit per resistor. When the bus reports the STOP that closes a write transaction, the block programs the whole two-byte page that the transaction touched. It then holds `busy` for a programmable number of clock cycles and raises `done` for one cycle when the commit is over.

After reset the block runs a recall phase that lasts a programmable number of cycles. During recall both resistor outputs are forced to high impedance and the write stream is back-pressured. At the end of recall every nonvolatile byte is copied from the array into the shadow bank in a single step. The two bytes of the volatile page hold the password being entered. They reset to FFh, are never copied from the array and are never committed to it.

The write stream follows the usual valid/ready rules. A beat is taken on a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low only during recall, and a source that sees it low keeps its beat steady until it is taken. A commit in progress does not back-pressure the stream.

Top module: `nv_page_commit`

## Requirements
- R1: While `rst_n` is low, and for exactly RECALL_CYCLES cycles after it rises, `recall_busy` is 1, `wr_ready` is 0, both `res0_hiz` and `res1_hiz` are 1, and `busy` and `done` are 0.
- R2: When recall ends, `rd_data` at every address returns the byte held in the array, except addresses 2*VOL_PAGE and 2*VOL_PAGE+1 (4 and 5 by default), which return FFh.
- R3: After `nv_rst_n` is pulsed low, the array holds the factory image: address 0 holds A0h, CFG_ADDR (1) holds 00h, RES0_ADDR (2) and RES1_ADDR (3) hold 7Fh, and every other address holds FFh.
- R4: A beat that is taken is visible on `rd_data` in the next cycle. From that cycle `res0_code` and `res1_code` show the bytes at RES0_ADDR and RES1_ADDR. `res0_hiz` follows bit 0 of the byte at CFG_ADDR and `res1_hiz` follows bit 1.
- R5: A `stop` pulse while idle, after at least one beat since the previous `stop`, makes `busy` 1 from the next cycle for exactly WRITE_CYCLES cycles. `done` is 1 for the single cycle after `busy` falls.
- R6: A commit writes both bytes of page {2p, 2p+1}. The byte that was not written in the transaction keeps the value it had in the shadow bank.
- R7: A transaction whose last beat hit the volatile page raises no `busy`, and the array keeps its old contents for that page.
- R8: A `stop` that arrives while `busy` is 1, including in the last busy cycle, is dropped. `busy` is neither lengthened nor restarted, and the beats of that transaction never reach the array.
- R9: Beats taken while `busy` is 1 update the shadow bank and the resistor outputs at once. The running commit stores the page contents as they were at the `stop` that started it.
- R10: A `stop` with no beat since the previous `stop` or reset starts no commit.
- R11: The page committed is the page of the last beat taken before `stop`. Beats to other pages in the same transaction stay in the shadow bank only.
- R12: `wr_ready` is 1 in every cycle outside recall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its release starts recall |
| nv_rst_n | input | 1 | Active-low load of the factory image into the backing array |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat accepted when high together with `wr_valid` |
| wr_addr | input | ADDR_W (5) | Byte address of the beat |
| wr_data | input | 8 | Data of the beat |
| stop | input | 1 | One-cycle strobe: the bus write transaction has ended |
| rd_addr | input | ADDR_W (5) | Shadow read address |
| rd_data | output | 8 | Shadow byte at `rd_addr` (combinational) |
| res0_code | output | 8 | Code of resistor 0 |
| res1_code | output | 8 | Code of resistor 1 |
| res0_hiz | output | 1 | Resistor 0 high impedance |
| res1_hiz | output | 1 | Resistor 1 high impedance |
| recall_busy | output | 1 | Recall in progress |
| busy | output | 1 | Page commit in progress |
| done | output | 1 | One-cycle pulse when a commit ends |

## Verification
Two things can happen in the same cycle. A new `stop` can arrive in the final busy cycle, on the very edge where the running commit writes the array and `busy` falls. Bus beats can also land in the shadow bank while a commit of that same page is still in flight. The bench provokes the first by placing a beat and a `stop` at chosen busy-cycle indices, the last one included. It judges the result by the unchanged busy length and the `done` timing, and by a later reset whose recall must show the values captured at the first `stop` and none of the dropped transaction.

// File: rtl/nvpc_pkg.sv
package nvpc_pkg;

  typedef enum logic [1:0] {
    SQ_RECALL = 2'd0,
    SQ_IDLE   = 2'd1,
    SQ_PROG   = 2'd2
  } seq_state_t;

  // Factory image of one byte of the backing array
  function automatic logic [7:0] factory_byte(input int unsigned a,
                                              input int unsigned cfg_a,
                                              input int unsigned r0_a,
                                              input int unsigned r1_a);
    if (a == 0)                      return 8'hA0;
    else if (a == cfg_a)             return 8'h00;
    else if (a == r0_a || a == r1_a) return 8'h7F;
    else                             return 8'hFF;
  endfunction

endpackage

// File: rtl/nvpc_array.sv
module nvpc_array #(
  parameter int N_BYTES   = 32,
  parameter int PAGE_W    = 4,
  parameter int CFG_ADDR  = 1,
  parameter int RES0_ADDR = 2,
  parameter int RES1_ADDR = 3,
  parameter int VOL_PAGE  = 2
) (
  input  logic                 clk,
  input  logic                 nv_rst_n,
  input  logic                 we,
  input  logic [PAGE_W-1:0]    page,
  input  logic [15:0]          wdata,
  output logic [N_BYTES*8-1:0] image
);
  import nvpc_pkg::*;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_cell
    localparam logic [7:0]        INIT  = factory_byte(i, CFG_ADDR, RES0_ADDR, RES1_ADDR);
    localparam logic [PAGE_W-1:0] MYPG  = PAGE_W'(i / 2);
    localparam int                LANE  = i % 2;
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge nv_rst_n) begin
      if (!nv_rst_n)                cell_q <= INIT;
      else if (we && page == MYPG)  cell_q <= wdata[LANE*8 +: 8];
    end
    assign image[i*8 +: 8] = cell_q;
  end

  // R7
  vol_never_written_chk: assert property (@(posedge clk) disable iff (!nv_rst_n)
    we |-> (page != PAGE_W'(VOL_PAGE)));

endmodule

// File: rtl/nvpc_shadow.sv
module nvpc_shadow #(
  parameter int N_BYTES  = 32,
  parameter int ADDR_W   = 5,
  parameter int VOL_PAGE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 load,
  input  logic [N_BYTES*8-1:0] image,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [7:0]           rd_data,
  output logic [N_BYTES*8-1:0] bank
);

  for (genvar i = 0; i < N_BYTES; i++) begin : g_reg
    localparam bit         IS_VOL = ((i / 2) == VOL_PAGE);
    localparam logic [7:0] RSTV   = IS_VOL ? 8'hFF : 8'h00;
    logic [7:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     sh_q <= RSTV;
      else if (load && !IS_VOL)                       sh_q <= image[i*8 +: 8];
      else if (wr_en && wr_addr == ADDR_W'(i))        sh_q <= wr_data;
    end
    assign bank[i*8 +: 8] = sh_q;
  end

  assign rd_data = bank[rd_addr*8 +: 8];

  // R4
  load_write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && wr_en));

endmodule

// File: rtl/nvpc_seq.sv
module nvpc_seq #(
  parameter int PAGE_W        = 4,
  parameter int WRITE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 16,
  parameter int VOL_PAGE      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              wr_fire,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [15:0]       page_data,
  output logic [PAGE_W-1:0] pend_page,
  output logic              recalling,
  output logic              load,
  output logic              busy,
  output logic              done,
  output logic              nv_we,
  output logic [PAGE_W-1:0] nv_page,
  output logic [15:0]       nv_wdata
);
  import nvpc_pkg::*;

  localparam int MAXC  = (WRITE_CYCLES > RECALL_CYCLES) ? WRITE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              dirty_q;
  logic [PAGE_W-1:0] pend_q;
  logic [PAGE_W-1:0] lat_page_q;
  logic [15:0]       lat_data_q;
  logic              done_q;
  logic              start_prog;

  assign start_prog = (state_q == SQ_IDLE) && stop && dirty_q &&
                      (pend_q != PAGE_W'(VOL_PAGE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_RECALL;
      cnt_q      <= CNT_W'(RECALL_CYCLES - 1);
      dirty_q    <= 1'b0;
      pend_q     <= '0;
      lat_page_q <= '0;
      lat_data_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (wr_fire) begin
        dirty_q <= 1'b1;
        pend_q  <= wr_page;
      end else if (stop) begin
        dirty_q <= 1'b0;
      end
      case (state_q)
        SQ_RECALL: begin
          if (cnt_q == '0) state_q <= SQ_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        SQ_IDLE: begin
          if (start_prog) begin
            state_q    <= SQ_PROG;
            cnt_q      <= CNT_W'(WRITE_CYCLES - 1);
            lat_page_q <= pend_q;
            lat_data_q <= page_data;
          end
        end
        SQ_PROG: begin
          if (cnt_q == '0) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign recalling = (state_q == SQ_RECALL);
  assign load      = recalling && (cnt_q == '0);
  assign busy      = (state_q == SQ_PROG);
  assign nv_we     = busy && (cnt_q == '0);
  assign nv_page   = lat_page_q;
  assign nv_wdata  = lat_data_q;
  assign done      = done_q;
  assign pend_page = pend_q;

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R5
  busy_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R8
  stop_in_prog_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop && !nv_we) |=> (busy && $stable(nv_page) && $stable(nv_wdata)));

endmodule

// File: rtl/nv_page_commit.sv
module nv_page_commit #(
  parameter int N_BYTES       = 32,
  parameter int WRITE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 16,
  parameter int CFG_ADDR      = 1,
  parameter int RES0_ADDR     = 2,
  parameter int RES1_ADDR     = 3,
  parameter int VOL_PAGE      = 2,
  localparam int ADDR_W       = $clog2(N_BYTES),
  localparam int PAGE_W       = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              stop,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        res0_code,
  output logic [7:0]        res1_code,
  output logic              res0_hiz,
  output logic              res1_hiz,
  output logic              recall_busy,
  output logic              busy,
  output logic              done
);

  logic [N_BYTES*8-1:0] image;
  logic [N_BYTES*8-1:0] bank;
  logic                 wr_fire;
  logic                 load;
  logic                 nv_we;
  logic [PAGE_W-1:0]    nv_page;
  logic [15:0]          nv_wdata;
  logic [PAGE_W-1:0]    pend_page;
  logic [15:0]          page_data;

  assign wr_ready  = !recall_busy;
  assign wr_fire   = wr_valid && wr_ready;
  assign page_data = bank[pend_page*16 +: 16];

  nvpc_array #(
    .N_BYTES(N_BYTES), .PAGE_W(PAGE_W), .CFG_ADDR(CFG_ADDR),
    .RES0_ADDR(RES0_ADDR), .RES1_ADDR(RES1_ADDR), .VOL_PAGE(VOL_PAGE)
  ) u_array (
    .clk(clk), .nv_rst_n(nv_rst_n), .we(nv_we), .page(nv_page),
    .wdata(nv_wdata), .image(image)
  );

  nvpc_shadow #(
    .N_BYTES(N_BYTES), .ADDR_W(ADDR_W), .VOL_PAGE(VOL_PAGE)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .image(image), .rd_addr(rd_addr),
    .rd_data(rd_data), .bank(bank)
  );

  nvpc_seq #(
    .PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES), .VOL_PAGE(VOL_PAGE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(stop), .wr_fire(wr_fire),
    .wr_page(wr_addr[ADDR_W-1:1]), .page_data(page_data),
    .pend_page(pend_page), .recalling(recall_busy), .load(load),
    .busy(busy), .done(done), .nv_we(nv_we), .nv_page(nv_page),
    .nv_wdata(nv_wdata)
  );

  assign res0_code = bank[RES0_ADDR*8 +: 8];
  assign res1_code = bank[RES1_ADDR*8 +: 8];
  assign res0_hiz  = recall_busy || bank[CFG_ADDR*8 + 0];
  assign res1_hiz  = recall_busy || bank[CFG_ADDR*8 + 1];

  // R1
  recall_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_busy |-> (res0_hiz && res1_hiz && !wr_ready && !busy));

  // R12
  ready_outside_recall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !recall_busy |-> wr_ready);

endmodule

// File: tb/sim_nv_page_commit.sv
module sim_nv_page_commit;
  localparam int WC   = 20;
  localparam int RC   = 8;
  localparam int VOLP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0, nv_rst_n = 1'b0;
  logic       wr_valid = 1'b0, stop = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, res0_hiz, res1_hiz, recall_busy, busy, done;
  logic [7:0] rd_data, res0_code, res1_code;

  int checks = 0, errors = 0;
  logic [7:0] exp_nv [32];
  logic [7:0] exp_sh [32];
  bit         dirty = 0;
  int         last_page = 0;

  always #2.5 clk = ~clk;

  nv_page_commit #(.WRITE_CYCLES(WC), .RECALL_CYCLES(RC), .VOL_PAGE(VOLP)) u0 (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .stop(stop),
    .rd_addr(rd_addr), .rd_data(rd_data), .res0_code(res0_code),
    .res1_code(res1_code), .res0_hiz(res0_hiz), .res1_hiz(res1_hiz),
    .recall_busy(recall_busy), .busy(busy), .done(done)
  );

  function automatic logic [7:0] factory(input int a);
    if (a == 0) return 8'hA0;
    if (a == 1) return 8'h00;
    if (a == 2 || a == 3) return 8'h7F;
    return 8'hFF;
  endfunction

  function automatic bit is_vol(input int a);
    return (a / 2) == VOLP;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset();
    int n = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", {busy, done}, 2'b00);
    rst_n = 1'b1;
    while (recall_busy && n < RC + 5) begin
      chk("R1 recall outputs", {res0_hiz, res1_hiz, wr_ready, busy}, 4'b1100);
      n++;
      @(negedge clk);
    end
    chk("R1 recall length", n, RC);
    chk("R12 ready after recall", wr_ready, 1'b1);
    for (int a = 0; a < 32; a++) exp_sh[a] = is_vol(a) ? 8'hFF : exp_nv[a];
    dirty = 0;
  endtask

  task automatic verify_all(input string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #0.5;
      chk(req, {a[7:0], rd_data}, {a[7:0], exp_sh[a]});
    end
  endtask

  task automatic check_outs(input string req);
    chk(req, {res0_code, res1_code, res0_hiz, res1_hiz},
        {exp_sh[2], exp_sh[3], exp_sh[1][0], exp_sh[1][1]});
  endtask

  // Starts just after a negedge; returns just after the next negedge
  task automatic beat(input int a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    exp_sh[a] = d; dirty = 1; last_page = a / 2;
  endtask

  // Counts busy cycles, optionally injecting a beat and a stop at busy indices
  task automatic wait_commit(input int wr_at, input int wa, input logic [7:0] wd,
                             input int stop_at, input string req);
    int n = 0;
    while (busy && n < WC + 5) begin
      n++;
      wr_valid = (n == wr_at); wr_addr = 5'(wa); wr_data = wd;
      stop = (n == stop_at);
      @(negedge clk);
      if (n == wr_at) begin
        exp_sh[wa] = wd; dirty = 1; last_page = wa / 2;
        rd_addr = 5'(wa); #0.5;
        chk({req, " shadow during busy R9"}, rd_data, wd);
      end
      if (n == stop_at) dirty = 0;
    end
    wr_valid = 1'b0; stop = 1'b0;
    chk({req, " busy length R5"}, n, WC);
    chk({req, " done pulse R5"}, done, 1'b1);
    @(negedge clk);
    chk({req, " done clears R5"}, {done, busy}, 2'b00);
  endtask

  task automatic end_txn(input int wr_at, input int wa, input logic [7:0] wd,
                         input int stop_at, input string req);
    bit expect_c = dirty && (last_page != VOLP);
    int pg = last_page;
    logic [7:0] lo = exp_sh[2*pg], hi = exp_sh[2*pg+1];
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0; dirty = 0;
    if (expect_c) begin
      chk({req, " busy starts R5"}, busy, 1'b1);
      wait_commit(wr_at, wa, wd, stop_at, req);
      exp_nv[2*pg] = lo; exp_nv[2*pg+1] = hi;
    end else begin
      chk({req, " no commit"}, busy, 1'b0);
      @(negedge clk);
      chk({req, " no commit later"}, {busy, done}, 2'b00);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 32; a++) exp_nv[a] = factory(a);
    @(negedge clk);
    nv_rst_n = 1'b1;
    do_reset();
    verify_all("R3 factory image");
    check_outs("R3 outputs after recall");

    // R4 and R11: cfg beat then resistor beat on another page
    beat(1, 8'h01);
    check_outs("R4 hiz follows cfg");
    beat(2, 8'h5A);
    check_outs("R4 code follows shadow");
    end_txn(0, 0, 8'h00, 0, "R11 last page");
    do_reset();
    verify_all("R11 cfg not stored, R2 recall");

    // R6: partial page write keeps partner byte
    beat(3, 8'h33);
    end_txn(0, 0, 8'h00, 0, "R6 partial page");
    do_reset();
    verify_all("R6 partner kept");

    // R7: volatile page never committed
    beat(4, 8'h12);
    beat(5, 8'h34);
    end_txn(0, 0, 8'h00, 0, "R7 volatile page");
    do_reset();
    verify_all("R7 volatile reads FF");

    // R10: stop with no beat
    end_txn(0, 0, 8'h00, 0, "R10 bare stop");

    // R8/R9: beat to the in-flight page during busy, stop mid-busy dropped
    beat(16, 8'h11);
    end_txn(3, 16, 8'h22, 5, "R8 mid stop");
    chk("R8 nothing pending", {busy, done}, 2'b00);
    end_txn(0, 0, 8'h00, 0, "R8 dropped txn stays dropped");

    // R8: stop in the last busy cycle, same cycle as commit end
    beat(18, 8'h77);
    end_txn(2, 19, 8'h99, WC, "R8 last cycle stop");
    do_reset();
    verify_all("R9 captured at stop, R8 dropped");

    // Random transactions
    for (int it = 0; it < 30; it++) begin
      int pg = int'($urandom % 16);
      int nb = 1 + int'($urandom % 2);
      for (int k = 0; k < nb; k++) begin
        int a = 2*pg + int'($urandom % 2);
        beat(a, 8'($urandom));
        check_outs("R4 random outputs");
      end
      end_txn(0, 0, 8'h00, 0, "R6 random commit");
      if (it % 10 == 9) begin
        do_reset();
        verify_all("R2 random recall");
      end
    end
    summary();
  end
endmodule